// File: doc/BRIEF.md
# Indirect Raw NAND Cycle Issuer

This block lets a host processor run a NAND flash device one bus cycle at a time through a small register window. The host first loads a window address word. A two-bit mode field near the top of that word picks the access style, and the two lowest bits pick the kind of raw cycle. The host then writes the data port, and that write starts one command latch, address latch or data read cycle on the flash pins. A read cycle captures the byte that the device drives. The host collects that byte, zero-extended, by reading the data port.

The block watches the device's ready/busy line once the host has issued the command that starts an array read. It then raises a ready flag in an interrupt-status register. That flag is write-one-to-clear. The setup, strobe and hold lengths of every cycle are fixed counts of clock cycles set by parameters. So is the shortest busy window that is assumed when the device never visibly pulls its busy line low.

Top module: `nand_raw_cycler`

## Requirements
- R1: After reset, CLE and ALE are low, WE_n and RE_n are high, the I/O output enable is low, `cyc_busy` is low, and the ready flag reads 0.
- R2: A write to offset 0x000 stores the full 32-bit window address word. A read of offset 0x000 returns that word.
- R3: While the window mode field (bits 27:26) is 3 and the cycle code (bits 1:0) is 0, a write to offset 0x010 runs a command cycle. CLE is high for the whole cycle and ALE is low. Data bits 7:0 are driven with the output enable high. WE_n is low for exactly PULSE_CYC clocks and then rises while CLE and the byte are still held.
- R4: Under the same conditions with cycle code 1, the write runs an address cycle. It behaves as in R3 with ALE in place of CLE.
- R5: With cycle code 2, the write runs a read cycle. RE_n is low for exactly PULSE_CYC clocks and the output enable stays low. The byte on `nf_io_in` in the last strobe clock is captured. A read of offset 0x010 then returns it in bits 7:0, with bits 31:8 zero.
- R6: A write to offset 0x010 causes no flash cycle when the mode field is not 3. It also causes none when the cycle code is 3.
- R7: A write to offset 0x010 that arrives while a cycle is in progress is ignored. No extra cycle follows it.
- R8: `cyc_busy` is high through every clock in which a cycle is in progress. WE_n and RE_n are low only while `cyc_busy` is high.
- R9: A completed command cycle with byte 0x30 arms the ready tracker. The ready flag (bit 12 of offset 0x410) then sets once the synchronised R/B_n line is high again after it has been seen low.
- R10: While armed, the ready flag does not set during the first BUSY_MIN armed clocks unless R/B_n has been seen low. It never sets while R/B_n is low. If R/B_n stays high, the flag sets once BUSY_MIN armed clocks have passed.
- R11: Writing offset 0x410 with bit 12 set clears the ready flag. Writing it with bit 12 clear leaves the flag as it was.
- R12: A clear write in the same clock as a ready set event leaves the ready flag set.
- R13: A command cycle with any byte other than 0x30 does not arm the tracker, and the ready flag stays 0.
- R14: CLE and ALE are never high together. WE_n and RE_n are never low together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe, one clock per write |
| bus_addr | input | 12 | Host register offset |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, decoded combinationally from bus_addr |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_out | output | 8 | Byte driven to the flash I/O bus |
| nf_io_oe | output | 1 | Output enable for nf_io_out |
| nf_io_in | input | 8 | Byte sampled from the flash I/O bus |
| nf_rb_n | input | 1 | Device ready/busy line, low while busy |
| cyc_busy | output | 1 | A raw cycle is in progress |

## Verification
The bench builds the block with PULSE_CYC set to 3 and BUSY_MIN set to 6. It leaves SETUP_CYC and HOLD_CYC at 1. A three-clock strobe makes the exact strobe-width checks sensitive to off-by-one counting. A six-clock minimum busy window is short enough that the bench can probe the flag both before and after that window expires. It can also hold a clear write across the exact clock in which the ready set event occurs.

// File: rtl/nrc_pkg.sv
package nrc_pkg;

    typedef enum logic [1:0] {
        KIND_CMD  = 2'd0,
        KIND_ADDR = 2'd1,
        KIND_READ = 2'd2,
        KIND_NONE = 2'd3
    } cyc_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_HOLD
    } phase_e;

    localparam logic [11:0] OFS_WIN_ADDR = 12'h000;
    localparam logic [11:0] OFS_WIN_DATA = 12'h010;
    localparam logic [11:0] OFS_IRQ_STAT = 12'h410;

    localparam int          MODE_LSB  = 26;
    localparam logic [1:0]  MODE_RAW  = 2'd3;
    localparam int          READY_BIT = 12;
    localparam logic [7:0]  CMD_GO    = 8'h30;

endpackage

// File: rtl/nrc_window.sv
module nrc_window
    import nrc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic [7:0]  rd_byte,
    input  logic        ready_stat,
    output logic        req,
    output cyc_kind_e   req_kind,
    output logic [7:0]  req_byte,
    output logic        irq_clr,
    output logic [31:0] bus_rdata
);

    typedef struct packed {
        logic [31:0] win;
    } win_state_t;

    win_state_t win_d, win_q;
    logic [1:0] mode;
    logic [1:0] code;

    assign mode = win_q.win[MODE_LSB+1:MODE_LSB];
    assign code = win_q.win[1:0];

    always_comb begin
        win_d = win_q;
        if (bus_wr && bus_addr == OFS_WIN_ADDR) begin
            win_d.win = bus_wdata;
        end

        req      = bus_wr && (bus_addr == OFS_WIN_DATA) && (mode == MODE_RAW) && (code != 2'd3);
        req_kind = cyc_kind_e'(code);
        req_byte = bus_wdata[7:0];
        irq_clr  = bus_wr && (bus_addr == OFS_IRQ_STAT) && bus_wdata[READY_BIT];

        case (bus_addr)
            OFS_WIN_ADDR: bus_rdata = win_q.win;
            OFS_WIN_DATA: bus_rdata = {24'h0, rd_byte};
            OFS_IRQ_STAT: bus_rdata = 32'(ready_stat) << READY_BIT;
            default:      bus_rdata = 32'h0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    // R6
    raw_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_WIN_DATA && mode != MODE_RAW) |-> !req);

endmodule

// File: rtl/nrc_cycle.sv
module nrc_cycle
    import nrc_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 2,
    parameter int HOLD_CYC  = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  cyc_kind_e  req_kind,
    input  logic [7:0] req_byte,
    input  logic [7:0] io_in,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic [7:0] io_out,
    output logic       io_oe,
    output logic       busy,
    output logic [7:0] rd_byte,
    output logic       done,
    output cyc_kind_e  done_kind,
    output logic [7:0] done_byte
);

    localparam int MAXC = (SETUP_CYC > PULSE_CYC) ?
                          ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                          ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

    typedef struct packed {
        phase_e          ph;
        logic [CW-1:0]   cnt;
        cyc_kind_e       kind;
        logic [7:0]      dat;
        logic [7:0]      rd;
    } cyc_state_t;

    cyc_state_t cyc_d, cyc_q;
    logic last;
    logic active;

    assign last   = (cyc_q.cnt == '0);
    assign active = (cyc_q.ph != PH_IDLE);

    always_comb begin
        cyc_d = cyc_q;
        case (cyc_q.ph)
            PH_IDLE: begin
                if (req) begin
                    cyc_d.ph   = PH_SETUP;
                    cyc_d.cnt  = CW'(SETUP_CYC - 1);
                    cyc_d.kind = req_kind;
                    cyc_d.dat  = req_byte;
                end
            end
            PH_SETUP: begin
                if (last) begin
                    cyc_d.ph  = PH_PULSE;
                    cyc_d.cnt = CW'(PULSE_CYC - 1);
                end else begin
                    cyc_d.cnt = cyc_q.cnt - 1'b1;
                end
            end
            PH_PULSE: begin
                if (last) begin
                    cyc_d.ph  = PH_HOLD;
                    cyc_d.cnt = CW'(HOLD_CYC - 1);
                    if (cyc_q.kind == KIND_READ) begin
                        cyc_d.rd = io_in;
                    end
                end else begin
                    cyc_d.cnt = cyc_q.cnt - 1'b1;
                end
            end
            default: begin
                if (last) begin
                    cyc_d.ph = PH_IDLE;
                end else begin
                    cyc_d.cnt = cyc_q.cnt - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q.ph   <= PH_IDLE;
            cyc_q.cnt  <= '0;
            cyc_q.kind <= KIND_NONE;
            cyc_q.dat  <= '0;
            cyc_q.rd   <= '0;
        end else begin
            cyc_q <= cyc_d;
        end
    end

    assign cle       = active && (cyc_q.kind == KIND_CMD);
    assign ale       = active && (cyc_q.kind == KIND_ADDR);
    assign we_n      = !((cyc_q.ph == PH_PULSE) && (cyc_q.kind != KIND_READ));
    assign re_n      = !((cyc_q.ph == PH_PULSE) && (cyc_q.kind == KIND_READ));
    assign io_out    = cyc_q.dat;
    assign io_oe     = active && (cyc_q.kind != KIND_READ);
    assign busy      = active;
    assign rd_byte   = cyc_q.rd;
    assign done      = (cyc_q.ph == PH_HOLD) && last;
    assign done_kind = cyc_q.kind;
    assign done_byte = cyc_q.dat;

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && active) |=> ($stable(cyc_q.dat) && $stable(cyc_q.kind)));

    // R14
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale) && !(!we_n && !re_n));

    // R3
    we_rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (busy && io_oe));

endmodule

// File: rtl/nrc_ready_irq.sv
module nrc_ready_irq
    import nrc_pkg::*;
#(
    parameter int BUSY_MIN = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rb_n,
    input  logic       done,
    input  cyc_kind_e  done_kind,
    input  logic [7:0] done_byte,
    input  logic       clr,
    output logic       stat
);

    localparam int TW = (BUSY_MIN > 0) ? $clog2(BUSY_MIN + 1) : 1;

    typedef struct packed {
        logic [1:0]    sync;
        logic          armed;
        logic          seen_low;
        logic [TW-1:0] tmr;
        logic          stat;
    } rdy_state_t;

    rdy_state_t rdy_d, rdy_q;
    logic rb_s;
    logic set_ev;

    assign rb_s   = rdy_q.sync[1];
    assign set_ev = rdy_q.armed && rb_s && (rdy_q.seen_low || rdy_q.tmr == TW'(BUSY_MIN));

    always_comb begin
        rdy_d      = rdy_q;
        rdy_d.sync = {rdy_q.sync[0], rb_n};
        if (rdy_q.armed) begin
            if (!rb_s) begin
                rdy_d.seen_low = 1'b1;
            end
            if (rdy_q.tmr != TW'(BUSY_MIN)) begin
                rdy_d.tmr = rdy_q.tmr + 1'b1;
            end
            if (set_ev) begin
                rdy_d.armed = 1'b0;
            end
        end
        if (done && done_kind == KIND_CMD && done_byte == CMD_GO) begin
            rdy_d.armed    = 1'b1;
            rdy_d.seen_low = 1'b0;
            rdy_d.tmr      = '0;
        end
        rdy_d.stat = set_ev || (rdy_q.stat && !clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q.sync     <= 2'b11;
            rdy_q.armed    <= 1'b0;
            rdy_q.seen_low <= 1'b0;
            rdy_q.tmr      <= '0;
            rdy_q.stat     <= 1'b0;
        end else begin
            rdy_q <= rdy_d;
        end
    end

    assign stat = rdy_q.stat;

    // R9
    set_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_q.stat) |-> $past(rdy_q.armed));

    // R10
    min_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_q.armed && !rdy_q.seen_low && rdy_q.tmr != TW'(BUSY_MIN)) |=> !$rose(rdy_q.stat));

    // R11
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set_ev) |=> !rdy_q.stat);

    // R12
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev |=> rdy_q.stat);

endmodule

// File: rtl/nand_raw_cycler.sv
module nand_raw_cycler
    import nrc_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 2,
    parameter int HOLD_CYC  = 1,
    parameter int BUSY_MIN  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        nf_cle,
    output logic        nf_ale,
    output logic        nf_we_n,
    output logic        nf_re_n,
    output logic [7:0]  nf_io_out,
    output logic        nf_io_oe,
    input  logic [7:0]  nf_io_in,
    input  logic        nf_rb_n,
    output logic        cyc_busy
);

    logic       req;
    cyc_kind_e  req_kind;
    logic [7:0] req_byte;
    logic       irq_clr;
    logic [7:0] rd_byte;
    logic       ready_stat;
    logic       done;
    cyc_kind_e  done_kind;
    logic [7:0] done_byte;

    nrc_window u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .rd_byte    (rd_byte),
        .ready_stat (ready_stat),
        .req        (req),
        .req_kind   (req_kind),
        .req_byte   (req_byte),
        .irq_clr    (irq_clr),
        .bus_rdata  (bus_rdata)
    );

    nrc_cycle #(
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) u_cycle (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_kind  (req_kind),
        .req_byte  (req_byte),
        .io_in     (nf_io_in),
        .cle       (nf_cle),
        .ale       (nf_ale),
        .we_n      (nf_we_n),
        .re_n      (nf_re_n),
        .io_out    (nf_io_out),
        .io_oe     (nf_io_oe),
        .busy      (cyc_busy),
        .rd_byte   (rd_byte),
        .done      (done),
        .done_kind (done_kind),
        .done_byte (done_byte)
    );

    nrc_ready_irq #(
        .BUSY_MIN (BUSY_MIN)
    ) u_ready (
        .clk       (clk),
        .rst_n     (rst_n),
        .rb_n      (nf_rb_n),
        .done      (done),
        .done_kind (done_kind),
        .done_byte (done_byte),
        .clr       (irq_clr),
        .stat      (ready_stat)
    );

    // R8
    strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cyc_busy) |-> (nf_we_n && nf_re_n && $past(nf_we_n) && $past(nf_re_n)));

endmodule

// File: tb/nand_raw_cycler_test.sv
module nand_raw_cycler_test;

    localparam int PULSE = 3;
    localparam int BMIN  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe, cyc_busy;
    logic [7:0]  nf_io_out;
    logic [7:0]  nf_io_in = 8'h00;
    logic        nf_rb_n = 1'b1;

    int total = 0;
    int bad = 0;
    int n_latch = 0;
    int n_push = 0;
    int n_read_pulse = 0;
    bit finished = 0;
    logic [9:0] exp_q[$];

    always #10 clk = ~clk;

    nand_raw_cycler #(
        .SETUP_CYC (1),
        .PULSE_CYC (PULSE),
        .HOLD_CYC  (1),
        .BUSY_MIN  (BMIN)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .nf_cle    (nf_cle),
        .nf_ale    (nf_ale),
        .nf_we_n   (nf_we_n),
        .nf_re_n   (nf_re_n),
        .nf_io_out (nf_io_out),
        .nf_io_oe  (nf_io_oe),
        .nf_io_in  (nf_io_in),
        .nf_rb_n   (nf_rb_n),
        .cyc_busy  (cyc_busy)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle();
        while (cyc_busy) @(negedge clk);
    endtask

    task automatic raw(input logic [1:0] code, input logic [7:0] b);
        if (code < 2) begin
            exp_q.push_back({code == 2'd0, code == 2'd1, b});
            n_push++;
        end
        bus_write(12'h000, 32'h0C00_0000 | 32'(code));
        bus_write(12'h010, 32'(b));
        wait_idle();
    endtask

    task automatic ready_flag(output logic f);
        logic [31:0] v;
        bus_read(12'h410, v);
        f = v[12];
    endtask

    // monitor: pops the scoreboard on every latched write strobe
    int we_low = 0;
    int re_low = 0;
    logic prev_we = 1'b1;
    logic prev_re = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (nf_cle && nf_ale) check(0, "R14 cle/ale overlap", 32'd1, 32'd0);
            if (!nf_we_n && !nf_re_n) check(0, "R14 we/re overlap", 32'd1, 32'd0);
            if ((!nf_we_n || !nf_re_n) && !cyc_busy) check(0, "R8 strobe without busy", 32'(cyc_busy), 32'd1);
            if (!nf_we_n) we_low++;
            if (!nf_re_n) re_low++;
            if (!prev_we && nf_we_n) begin
                n_latch++;
                check(we_low == PULSE, "R3 we_n low width", 32'(we_low), 32'(PULSE));
                if (exp_q.size() == 0) begin
                    check(0, "R7 unexpected latch", {22'h0, nf_cle, nf_ale, nf_io_out}, 32'h0);
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    check({nf_cle, nf_ale, nf_io_out} == e && nf_io_oe,
                          e[9] ? "R3 command latch" : "R4 address latch",
                          {21'h0, nf_io_oe, nf_cle, nf_ale, nf_io_out}, {21'h0, 1'b1, e});
                end
                we_low = 0;
            end
            if (!prev_re && nf_re_n) begin
                n_read_pulse++;
                check(re_low == PULSE, "R5 re_n low width", 32'(re_low), 32'(PULSE));
                re_low = 0;
            end
            if (!nf_re_n && nf_io_oe) check(0, "R5 oe during read", 32'd1, 32'd0);
            prev_we = nf_we_n;
            prev_re = nf_re_n;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic f;
        int cnt;
        int lat0;
        int rp0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(!nf_cle && !nf_ale && nf_we_n && nf_re_n && !nf_io_oe && !cyc_busy,
              "R1 pins idle", {26'h0, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe, cyc_busy}, 32'b001100);
        ready_flag(f);
        check(f == 1'b0, "R1 ready flag", 32'(f), 32'd0);

        // R2 window address readback
        bus_write(12'h000, 32'hA5C3_0F12);
        bus_read(12'h000, v);
        check(v == 32'hA5C3_0F12, "R2 window readback", v, 32'hA5C3_0F12);

        // R3/R4 page-read style sequence through the scoreboard
        raw(2'd0, 8'h00);
        raw(2'd1, 8'h40);
        raw(2'd1, 8'h08);
        raw(2'd1, 8'h80);
        raw(2'd1, 8'h01);
        raw(2'd1, 8'h00);
        repeat (2) @(negedge clk);
        check(n_latch == n_push, "R4 latch count", 32'(n_latch), 32'(n_push));

        // R5 read cycles, zero extension
        rp0 = n_read_pulse;
        nf_io_in = 8'hA5;
        raw(2'd2, 8'hFF);
        nf_io_in = 8'h00;
        bus_read(12'h010, v);
        check(v == 32'h0000_00A5, "R5 read byte", v, 32'h0000_00A5);
        nf_io_in = 8'h3C;
        raw(2'd2, 8'h00);
        bus_read(12'h010, v);
        check(v == 32'h0000_003C, "R5 second read byte", v, 32'h0000_003C);
        check(n_read_pulse == rp0 + 2, "R5 read pulse count", 32'(n_read_pulse), 32'(rp0 + 2));

        // R6 wrong mode or code 3: no cycle
        lat0 = n_latch;
        bus_write(12'h000, 32'h0800_0000);
        bus_write(12'h010, 32'h0000_0055);
        check(!cyc_busy, "R6 mode 2 busy", 32'(cyc_busy), 32'd0);
        bus_write(12'h000, 32'h0C00_0003);
        bus_write(12'h010, 32'h0000_0066);
        check(!cyc_busy, "R6 code 3 busy", 32'(cyc_busy), 32'd0);
        repeat (8) @(negedge clk);
        check(n_latch == lat0 && n_read_pulse == rp0 + 2, "R6 no strobe", 32'(n_latch), 32'(lat0));

        // R7 write while busy is dropped, R8 busy after start
        bus_write(12'h000, 32'h0C00_0000);
        exp_q.push_back({1'b1, 1'b0, 8'h11}); n_push++;
        bus_write(12'h010, 32'h0000_0011);
        check(cyc_busy, "R8 busy after start", 32'(cyc_busy), 32'd1);
        bus_write(12'h010, 32'h0000_0022);
        wait_idle();
        repeat (8) @(negedge clk);
        check(n_latch == n_push && exp_q.size() == 0, "R7 single latch", 32'(n_latch), 32'(n_push));

        // R13 other command does not arm
        raw(2'd0, 8'h70);
        repeat (BMIN + 10) @(negedge clk);
        ready_flag(f);
        check(f == 1'b0, "R13 not armed", 32'(f), 32'd0);

        // R9/R10 busy seen low path
        raw(2'd0, 8'h30);
        nf_rb_n = 1'b0;
        repeat (BMIN + 10) @(negedge clk);
        ready_flag(f);
        check(f == 1'b0, "R10 not set while busy low", 32'(f), 32'd0);
        nf_rb_n = 1'b1;
        repeat (6) @(negedge clk);
        ready_flag(f);
        check(f == 1'b1, "R9 set after busy ends", 32'(f), 32'd1);

        // R11 write-one-to-clear
        bus_write(12'h410, 32'h0000_0000);
        ready_flag(f);
        check(f == 1'b1, "R11 zero write keeps", 32'(f), 32'd1);
        bus_write(12'h410, 32'hFFFF_EFFF);
        ready_flag(f);
        check(f == 1'b1, "R11 other bits keep", 32'(f), 32'd1);
        bus_write(12'h410, 32'h0000_1000);
        ready_flag(f);
        check(f == 1'b0, "R11 clear", 32'(f), 32'd0);

        // R10 minimum busy path, line never low
        raw(2'd0, 8'h30);
        repeat (2) @(negedge clk);
        ready_flag(f);
        check(f == 1'b0, "R10 early no set", 32'(f), 32'd0);
        repeat (BMIN + 6) @(negedge clk);
        ready_flag(f);
        check(f == 1'b1, "R10 set after min busy", 32'(f), 32'd1);
        bus_write(12'h410, 32'h0000_1000);

        // R12 clear held across the set event
        raw(2'd0, 8'h30);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h410; bus_wdata = 32'h0000_1000;
        cnt = 0;
        for (int i = 0; i < BMIN + 12; i++) begin
            @(negedge clk);
            #1;
            if (bus_rdata[12]) cnt++;
        end
        bus_wr = 1'b0;
        check(cnt == 1, "R12 set wins over clear", 32'(cnt), 32'd1);
        ready_flag(f);
        check(f == 1'b0, "R12 cleared afterwards", 32'(f), 32'd0);

        check(exp_q.size() == 0, "R3 scoreboard drained", 32'(exp_q.size()), 32'd0);

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule